// File: doc/BRIEF.md
# One-Wire Bus Timing Master

This block drives a single open-drain serial line carrying a one-wire protocol. A host issues one command at a time over a valid/ready port. The block then produces the timed line waveform for that command. Slot commands are a bus reset with presence detection, a write-0 slot, a write-1 slot and a read slot. Level commands are strong pull-up on, pull-up off, and a forced hard pull-down. When a command finishes, the block pulses a done strobe together with the sampled bit (for a read) or the presence flag (for a reset).

The pad is controlled by two enables. One pulls the line low. The other actively drives the line high to feed parasite-powered devices. The line level comes back through an internal two-flop synchroniser. All durations are whole microseconds. A prescaler of `CLK_PER_US` system clocks produces the microsecond tick, and a single down-counter counts each phase in those ticks.

Top module: `owm_master`

## Requirements
- R1: Out of reset, `cmd_ready` is 1, `pull_low`, `drive_high` and `rsp_done` are 0.
- R2: A command is taken on a clock where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the done strobe. On the clock after acceptance both pad enables are 0 (the settle clock).
- R3: Code 0 (bus reset) holds `pull_low` for 500 µs and then releases the line. The line is sampled 60 µs after the release. Done follows a further 421 µs later. `rsp_bit` is 1 when the sampled line was low, and 0 otherwise.
- R4: Code 1 (write 0) holds `pull_low` for 60 µs, then releases the line for 1 µs before done. `rsp_bit` is 0.
- R5: Code 2 (write 1) holds `pull_low` for 10 µs, then releases the line for 51 µs before done. `rsp_bit` is 0.
- R6: Code 3 (read) holds `pull_low` for 5 µs and then releases the line. The line is sampled 6 µs after the release and the level is returned as `rsp_bit` (high = 1). Done follows 50 µs of recovery.
- R7: Code 4 turns on `drive_high` from the clock after the settle clock. It stays on while the block is idle, until code 5, code 7, code 6 or any slot command.
- R8: Codes 5 and 7 leave both pad enables at 0 while idle.
- R9: Code 6 asserts `pull_low` from the clock after the settle clock. It holds the line low with no time limit until another command is accepted.
- R10: `pull_low` and `drive_high` are never 1 together. Neither enable rises on a clock where the other was 1 just before.
- R11: A phase of N µs lasts exactly N·`CLK_PER_US` clocks, counted from the clock after the settle clock. Done for a slot arrives 1 + total·`CLK_PER_US` clocks after acceptance.
- R12: The line level matters only at the sample instant. A low glitch during the recovery phase of a read or a reset does not change `rsp_bit`.
- R13: A level command (codes 4 to 7) gives its done strobe on the clock after the settle clock, with `rsp_bit` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_code | input | 3 | 0 reset, 1 write-0, 2 write-1, 3 read, 4 pull-up on, 5 pull-up off, 6 force low, 7 release |
| cmd_ready | output | 1 | Block idle and able to take a command |
| line_in | input | 1 | Raw line level from the pad |
| pull_low | output | 1 | Enable of the pad's low driver |
| drive_high | output | 1 | Enable of the pad's strong high driver |
| rsp_done | output | 1 | One-clock strobe at command completion |
| rsp_bit | output | 1 | Read bit or presence flag, valid with the strobe |

## Verification
The bench builds the block with `CLK_PER_US` set to 4 and leaves every microsecond budget at its default. Each phase therefore stays at its true length in ticks, while a full bus reset costs under 4000 clocks. This lets randomly mixed reset, write and read slots with random device responses run to completion, with their exact low-time and done-clock checked. With four clocks per tick, an error of a single clock or of a single tick in a phase boundary changes the measured counts. The level commands are exercised in directed sequences that cross between strong pull-up and forced low.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam logic [2:0] OP_BUS_RESET = 3'd0;
  localparam logic [2:0] OP_WRITE0    = 3'd1;
  localparam logic [2:0] OP_WRITE1    = 3'd2;
  localparam logic [2:0] OP_READ      = 3'd3;
  localparam logic [2:0] OP_SPU_ON    = 3'd4;
  localparam logic [2:0] OP_SPU_OFF   = 3'd5;
  localparam logic [2:0] OP_FORCE_LOW = 3'd6;
  localparam logic [2:0] OP_RELEASE   = 3'd7;

  typedef enum logic [1:0] {
    PAD_FLOAT  = 2'd0,
    PAD_STRONG = 2'd1,
    PAD_FORCED = 2'd2
  } pad_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_LOW    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_REC    = 3'd4
  } seq_state_t;

  // Slot commands occupy codes 0..3 (top bit clear).
  function automatic logic is_slot(input logic [2:0] c);
    return c[2] == 1'b0;
  endfunction
endpackage

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (CLK_PER_US <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(CLK_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n || restart) pre <= '0;
        else if (pre == LAST) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign tick = (pre == LAST);

      assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/owm_slot_seq.sv
module owm_slot_seq
  import owm_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int RST_LOW_US  = 500,
  parameter int RST_WAIT_US = 60,
  parameter int RST_TAIL_US = 421,
  parameter int W0_LOW_US   = 60,
  parameter int W0_REL_US   = 1,
  parameter int W1_LOW_US   = 10,
  parameter int W1_REL_US   = 51,
  parameter int RD_LOW_US   = 5,
  parameter int RD_WAIT_US  = 6,
  parameter int RD_REC_US   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       cmd_ready,
  input  logic       line_s,
  input  logic       tick,
  output logic       tick_restart,
  output logic       pull_low,
  output logic       drive_high,
  output logic       rsp_done,
  output logic       rsp_bit
);
  // Phase selector for the budget function: 0 low, 1 wait-to-sample, 2 recovery.
  function automatic logic [CNT_W-1:0] us_budget(input logic [2:0] c, input logic [1:0] ph);
    int v;
    v = 0;
    case (c)
      OP_BUS_RESET: v = (ph == 2'd0) ? RST_LOW_US : (ph == 2'd1) ? RST_WAIT_US : RST_TAIL_US;
      OP_WRITE0:    v = (ph == 2'd0) ? W0_LOW_US  : (ph == 2'd1) ? W0_REL_US   : 0;
      OP_WRITE1:    v = (ph == 2'd0) ? W1_LOW_US  : (ph == 2'd1) ? W1_REL_US   : 0;
      OP_READ:      v = (ph == 2'd0) ? RD_LOW_US  : (ph == 2'd1) ? RD_WAIT_US  : RD_REC_US;
      default:      v = 0;
    endcase
    return CNT_W'(v);
  endfunction

  seq_state_t       state;
  pad_mode_t        mode;
  logic [2:0]       op_q;
  logic [CNT_W-1:0] cnt;

  // Named internal events.
  logic accept, phase_end, sample_now;
  logic [CNT_W-1:0] rec_len;
  assign accept     = cmd_valid && cmd_ready;
  assign phase_end  = tick && (cnt == CNT_W'(1));
  assign sample_now = (state == ST_WAIT) && phase_end;
  assign rec_len    = us_budget(op_q, 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode     <= PAD_FLOAT;
      op_q     <= '0;
      cnt      <= '0;
      rsp_done <= 1'b0;
      rsp_bit  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= cmd_code;
          mode  <= PAD_FLOAT;
          state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (is_slot(op_q)) begin
            cnt   <= us_budget(op_q, 2'd0);
            state <= ST_LOW;
          end else begin
            case (op_q)
              OP_SPU_ON:    mode <= PAD_STRONG;
              OP_FORCE_LOW: mode <= PAD_FORCED;
              default:      mode <= PAD_FLOAT;
            endcase
            rsp_bit  <= 1'b0;
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            cnt   <= us_budget(op_q, 2'd1);
            state <= ST_WAIT;
          end else if (tick) cnt <= cnt - 1'b1;
        end
        ST_WAIT: begin
          if (phase_end) begin
            if (op_q == OP_BUS_RESET) rsp_bit <= !line_s;
            else if (op_q == OP_READ) rsp_bit <= line_s;
            else rsp_bit <= 1'b0;
            if (rec_len != '0) begin
              cnt   <= rec_len;
              state <= ST_REC;
            end else begin
              rsp_done <= 1'b1;
              state    <= ST_IDLE;
            end
          end else if (tick) cnt <= cnt - 1'b1;
        end
        ST_REC: begin
          if (phase_end) begin
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end else if (tick) cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign tick_restart = (state == ST_SETTLE);
  assign pull_low     = (state == ST_LOW) || ((state == ST_IDLE) && (mode == PAD_FORCED));
  assign drive_high   = (state == ST_IDLE) && (mode == PAD_STRONG);

  assert_settle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!pull_low && !drive_high));
  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !rsp_done) |=> (!cmd_ready || rsp_done));
  assert_done_after_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(!cmd_ready));
  assert_high_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_high) |-> $past(!pull_low));
  assert_low_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> $past(!drive_high));
  assert_count_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW || state == ST_WAIT || state == ST_REC) |-> (cnt != '0));
  assert_sample_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && $past(state == ST_REC)) |-> $stable(rsp_bit));
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int CLK_PER_US  = 100,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 500,
  parameter int RST_WAIT_US = 60,
  parameter int RST_TAIL_US = 421,
  parameter int W0_LOW_US   = 60,
  parameter int W0_REL_US   = 1,
  parameter int W1_LOW_US   = 10,
  parameter int W1_REL_US   = 51,
  parameter int RD_LOW_US   = 5,
  parameter int RD_WAIT_US  = 6,
  parameter int RD_REC_US   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       cmd_ready,
  input  logic       line_in,
  output logic       pull_low,
  output logic       drive_high,
  output logic       rsp_done,
  output logic       rsp_bit
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_US = max2(max2(max2(RST_LOW_US, RST_WAIT_US), max2(RST_TAIL_US, W0_LOW_US)),
                               max2(max2(W0_REL_US, W1_LOW_US), max2(max2(W1_REL_US, RD_LOW_US),
                                    max2(RD_WAIT_US, RD_REC_US))));
  localparam int CNT_W = $clog2(MAX_US + 1);

  logic line_s, tick, tick_restart;

  owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tick_restart), .tick(tick)
  );

  owm_slot_seq #(
    .CNT_W(CNT_W),
    .RST_LOW_US(RST_LOW_US), .RST_WAIT_US(RST_WAIT_US), .RST_TAIL_US(RST_TAIL_US),
    .W0_LOW_US(W0_LOW_US), .W0_REL_US(W0_REL_US),
    .W1_LOW_US(W1_LOW_US), .W1_REL_US(W1_REL_US),
    .RD_LOW_US(RD_LOW_US), .RD_WAIT_US(RD_WAIT_US), .RD_REC_US(RD_REC_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
    .line_s(line_s), .tick(tick), .tick_restart(tick_restart),
    .pull_low(pull_low), .drive_high(drive_high),
    .rsp_done(rsp_done), .rsp_bit(rsp_bit)
  );
endmodule

// File: tb/owm_master_bench.sv
module owm_master_bench;
  localparam int K = 4;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic cmd_ready, pull_low, drive_high, rsp_done, rsp_bit;
  logic dev_level = 1'b1;
  logic glitch = 1'b0;
  logic line_in;

  int checks = 0;
  int fails = 0;
  int both_on = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Open-drain line: low driver and a low-pulling device win over the pull-up.
  assign line_in = pull_low ? 1'b0 : drive_high ? 1'b1 : (dev_level & ~glitch);

  owm_master #(.CLK_PER_US(K)) u_owm_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .line_in(line_in), .pull_low(pull_low),
    .drive_high(drive_high), .rsp_done(rsp_done), .rsp_bit(rsp_bit)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (pull_low && drive_high) both_on <= both_on + 1;
  end

  // Bench restatement of slot budgets (microseconds): low, release, recovery.
  function automatic int exp_low(input int c);
    case (c) 0: return 500; 1: return 60; 2: return 10; default: return 5; endcase
  endfunction
  function automatic int exp_total(input int c);
    case (c) 0: return 981; 1: return 61; 2: return 61; default: return 61; endcase
  endfunction
  function automatic logic exp_bit(input int c, input logic lvl);
    if (c == 0) return ~lvl;
    if (c == 3) return lvl;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int low_cyc, first_low, done_idx, settle_ok, busy_bad;
  logic got_bit;

  // Issue one command; index i counts negedges after the accepting edge.
  task automatic run_cmd(input logic [2:0] code, input logic lvl, input int glitch_at);
    low_cyc = 0; first_low = -1; done_idx = -1; settle_ok = 0; busy_bad = 0; got_bit = 1'b0;
    @(negedge clk);
    dev_level = lvl;
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    settle_ok = (!pull_low && !drive_high) ? 1 : 0;
    for (int i = 1; i < 6000; i++) begin
      @(negedge clk);
      if (i == glitch_at) glitch = 1'b1;
      if (i == glitch_at + 3) glitch = 1'b0;
      if (pull_low) begin
        low_cyc++;
        if (first_low < 0) first_low = i;
      end
      if (rsp_done) begin
        done_idx = i;
        got_bit = rsp_bit;
        break;
      end
      if (cmd_ready) busy_bad++;
    end
    glitch = 1'b0;
  endtask

  task automatic check_slot(input int c, input logic lvl, input string tag);
    check(settle_ok == 1, {tag, " R2 settle release"}, settle_ok, 1);
    check(busy_bad == 0, {tag, " R2 ready low while busy"}, busy_bad, 0);
    check(low_cyc == exp_low(c) * K && first_low == 1, {tag, " low time"}, low_cyc, exp_low(c) * K);
    check(done_idx == 1 + exp_total(c) * K, {tag, " R11 done clock"}, done_idx, 1 + exp_total(c) * K);
    check(got_bit == exp_bit(c, lvl), {tag, " result bit"}, int'(got_bit), int'(exp_bit(c, lvl)));
  endtask

  task automatic tag_for(input int c, output string s);
    case (c) 0: s = "R3"; 1: s = "R4"; 2: s = "R5"; default: s = "R6"; endcase
  endtask

  initial begin
    #(WATCHDOG * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    string t;
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state out of reset
    check(cmd_ready && !pull_low && !drive_high && !rsp_done, "R1 reset state",
          {cmd_ready, pull_low, drive_high, rsp_done}, 4'b1000);
    // R2: no valid, nothing changes
    repeat (20) @(negedge clk);
    check(cmd_ready && !pull_low && !rsp_done, "R2 idle without valid", int'(pull_low), 0);

    // Directed slots, each code with both device levels
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 2; l++) begin
        tag_for(c, t);
        run_cmd(3'(c), l[0], -10);
        check_slot(c, l[0], t);
      end
    end

    // R12: glitch during read recovery and reset tail
    run_cmd(3'd3, 1'b1, 1 + (5 + 6) * K + 8);
    check(got_bit == 1'b1, "R12 read glitch in recovery", int'(got_bit), 1);
    run_cmd(3'd0, 1'b1, 1 + (500 + 60) * K + 40);
    check(got_bit == 1'b0, "R12 reset glitch in tail", int'(got_bit), 0);

    // Random slot mix
    for (int n = 0; n < 14; n++) begin
      int c;
      logic l;
      c = int'($urandom_range(3, 0));
      l = 1'($urandom_range(1, 0));
      tag_for(c, t);
      run_cmd(3'(c), l, -10);
      check_slot(c, l, {t, " random"});
    end

    // R7 / R13: strong pull-up on and held
    run_cmd(3'd4, 1'b1, -10);
    check(settle_ok == 1 && done_idx == 1, "R13 pull-up on done", done_idx, 1);
    check(drive_high && !pull_low && got_bit == 1'b0, "R7 pull-up active", int'(drive_high), 1);
    repeat (200) @(negedge clk);
    check(drive_high && cmd_ready, "R7 pull-up held", int'(drive_high), 1);
    // R10: pull-up to forced low goes through a released clock
    run_cmd(3'd6, 1'b1, -10);
    check(settle_ok == 1, "R10 handover high to low", settle_ok, 1);
    check(pull_low && !drive_high && done_idx == 1, "R9 forced low active", int'(pull_low), 1);
    repeat (500) @(negedge clk);
    check(pull_low && cmd_ready, "R9 forced low held", int'(pull_low), 1);
    run_cmd(3'd4, 1'b1, -10);
    check(settle_ok == 1 && drive_high && !pull_low, "R10 handover low to high", int'(drive_high), 1);
    // R7: a slot command cancels the pull-up
    run_cmd(3'd2, 1'b1, -10);
    check_slot(2, 1'b1, "R7 slot after pull-up");
    @(negedge clk);
    check(!drive_high && !pull_low, "R7 pull-up cancelled by slot", int'(drive_high), 0);
    // R8: code 5 and code 7 release
    run_cmd(3'd4, 1'b1, -10);
    run_cmd(3'd5, 1'b1, -10);
    repeat (5) @(negedge clk);
    check(!drive_high && !pull_low && done_idx == 1, "R8 pull-up off", int'(drive_high), 0);
    run_cmd(3'd6, 1'b1, -10);
    run_cmd(3'd7, 1'b1, -10);
    repeat (5) @(negedge clk);
    check(!drive_high && !pull_low && got_bit == 1'b0, "R8 release after forced low", int'(pull_low), 0);

    check(both_on == 0, "R10 never both enables", both_on, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule